// File: doc/BRIEF.md
# Page Write Collector and Timed Commit Controller

This block sits behind a two-wire slave engine in a byte-addressed non-volatile store of 2048 bytes, organised as 128 pages of 16 bytes. The slave engine reports bus events to it: the start and stop conditions, the loading of the starting byte address, and each completed data byte of a write. The block gathers the data bytes of one write transaction into a one-page buffer, and each slot of the buffer carries a valid flag. Successive bytes go to successive slots. When the low address runs past the end of a page it wraps back to slot 0 of the same page.

A stop condition that ends a transaction holding at least one buffered byte starts a self-timed commit cycle. During the first cycles of that commit the buffered bytes are written, one per clock, through a memory write port into a synthesizable array model. A busy flag then stays high for a fixed number of clocks, set by a parameter, which models the programming time. While busy is high, all bus events are ignored.

Bytes flagged by the slave engine as going only to the volatile wiper register are not buffered. A transaction made up only of such bytes ends without a commit cycle. A start condition that arrives before the stop discards whatever has been buffered.

Top module: `page_write_ctrl`

## Requirements
- R1: A pulse on `addr_load` sets the page from `addr_in[10:4]` and the slot from `addr_in[3:0]`. Each later `byte_stb` with `byte_vol`=0 stores `byte_data` at the current slot, and each strobe then moves the slot forward by one.
- R2: The slot advances modulo 16, so the byte after slot 15 goes to slot 0 of the same page and never to the next page.
- R3: When `stop_evt` is sampled with at least one byte buffered, `busy` rises on the next clock and stays high for exactly CYCLE_CLKS clock cycles. `busy` never rises except after a sampled `stop_evt`.
- R4: A `stop_evt` with no buffered byte leaves `busy` low and writes nothing.
- R5: During a commit, `mem_we` pulses exactly once for each buffered slot, in ascending slot order, with `mem_addr` = {page, slot}. All of these pulses fall within the first 16 busy cycles, and `mem_we` is never high while `busy` is low. Bytes of the page that were not buffered keep their old contents.
- R6: While `busy` is high, `start_evt`, `stop_evt`, `addr_load` and `byte_stb` have no effect. The target page does not change and no byte is buffered.
- R7: A `start_evt` outside a commit discards all buffered bytes.
- R8: A strobe with `byte_vol`=1 is not buffered but still advances the slot.
- R9: After reset, `busy` and `mem_we` are low and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-clock pulse: start condition seen |
| stop_evt | input | 1 | One-clock pulse: stop condition seen |
| addr_load | input | 1 | One-clock pulse: starting address is valid |
| addr_in | input | 11 | Starting byte address |
| byte_stb | input | 1 | One-clock pulse: a complete data byte was received |
| byte_data | input | 8 | Received data byte |
| byte_vol | input | 1 | The strobed byte targets only the volatile register |
| busy | output | 1 | Commit cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |
| rd_addr | input | 11 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
The assertions check the following on every cycle:
- busy rises only after a stop and lasts exactly CYCLE_CLKS clocks;
- array writes occur only while busy, within the first 16 busy cycles, in strictly rising slot order;
- the target page holds steady for the whole commit.

Other behaviour can only be shown by the directed scenarios, which read the array back through the read port:
- which bytes actually land and where;
- wrap within the page;
- volatile-only and empty transactions that skip the cycle;
- buffers discarded by a start;
- events ignored during a commit.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   typedef enum logic {
      CYC_IDLE = 1'b0,
      CYC_RUN  = 1'b1
   } cyc_state_e;
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                load,
   input  logic [ADDR_W-1:0]                   load_addr,
   input  logic                                stb,
   input  logic                                vol,
   input  logic [DATA_W-1:0]                   din,
   input  logic                                clear,
   output logic [ADDR_W-PAGE_W-1:0]            page_o,
   output logic [(1<<PAGE_W)-1:0]              valid_o,
   output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]  data_o
);
   localparam int SLOTS = 1 << PAGE_W;

   logic [PAGE_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         page_o <= '0;
      end else if (load) begin
         ptr    <= load_addr[PAGE_W-1:0];
         page_o <= load_addr[ADDR_W-1:PAGE_W];
      end else if (stb) begin
         ptr <= ptr + 1'b1;
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o[s] <= 1'b0;
            data_o[s]  <= '0;
         end else if (clear) begin
            valid_o[s] <= 1'b0;
         end else if (stb && !vol && ptr == PAGE_W'(s)) begin
            valid_o[s] <= 1'b1;
            data_o[s]  <= din;
         end
      end
   end
endmodule

// File: rtl/pwc_cycle_ctrl.sv
module pwc_cycle_ctrl
   import pwc_pkg::*;
#(
   parameter int PAGE_W     = 4,
   parameter int CYCLE_CLKS = 600000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop,
   input  logic              pending,
   output logic              busy,
   output logic              slot_live,
   output logic [PAGE_W-1:0] slot,
   output logic              done
);
   localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

   cyc_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [PAGE_W:0]  sidx;

   assign busy      = (state == CYC_RUN);
   assign done      = busy && (cnt == CNT_W'(CYCLE_CLKS - 1));
   assign slot_live = busy && !sidx[PAGE_W];
   assign slot      = sidx[PAGE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CYC_IDLE;
         cnt   <= '0;
         sidx  <= '0;
      end else if (state == CYC_IDLE) begin
         cnt  <= '0;
         sidx <= '0;
         if (stop && pending) state <= CYC_RUN;
      end else begin
         cnt <= cnt + 1'b1;
         if (!sidx[PAGE_W]) sidx <= sidx + 1'b1;
         if (done) state <= CYC_IDLE;
      end
   end
endmodule

// File: rtl/pwc_nv_array.sv
module pwc_nv_array #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter bit RST_CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   assign rdata = cells[raddr];

   if (RST_CLEAR) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
         end else if (we) begin
            cells[waddr] <= wdata;
         end
      end
   end else begin : g_keep
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (we) cells[waddr] <= wdata;
      end
   end
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
   parameter int ADDR_W     = 11,
   parameter int PAGE_W     = 4,
   parameter int DATA_W     = 8,
   parameter int CYCLE_CLKS = 600000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_stb,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              byte_vol,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int SLOTS = 1 << PAGE_W;
   localparam int PG_W  = ADDR_W - PAGE_W;

   initial begin
      assert (PAGE_W >= 1 && PAGE_W < ADDR_W) else $error("page width out of range");
      assert (CYCLE_CLKS >= SLOTS) else $error("cycle shorter than one page");
   end

   logic [PG_W-1:0]               page;
   logic [SLOTS-1:0]              valid;
   logic [SLOTS-1:0][DATA_W-1:0]  data;
   logic                          slot_live, done;
   logic [PAGE_W-1:0]             slot;
   logic                          clr;

   assign clr = done || (start_evt && !busy);

   pwc_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) buf_i (
      .clk(clk), .rst_n(rst_n),
      .load(addr_load && !busy), .load_addr(addr_in),
      .stb(byte_stb && !busy), .vol(byte_vol), .din(byte_data),
      .clear(clr), .page_o(page), .valid_o(valid), .data_o(data)
   );

   pwc_cycle_ctrl #(.PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)) ctl_i (
      .clk(clk), .rst_n(rst_n), .stop(stop_evt), .pending(|valid),
      .busy(busy), .slot_live(slot_live), .slot(slot), .done(done)
   );

   assign mem_we    = slot_live && valid[slot];
   assign mem_addr  = {page, slot};
   assign mem_wdata = data[slot];

   pwc_nv_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CLEAR(1'b1)) arr_i (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
      .raddr(rd_addr), .rdata(rd_data)
   );
endmodule

// File: rtl/page_write_ctrl_chk.sv
module page_write_ctrl_chk #(
   parameter int ADDR_W     = 11,
   parameter int PAGE_W     = 4,
   parameter int CYCLE_CLKS = 600000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_evt,
   input logic              busy,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam int SLOTS = 1 << PAGE_W;
   localparam int CW    = $clog2(CYCLE_CLKS + 2) + 1;

   logic [CW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bcnt <= '0;
      else        bcnt <= busy ? bcnt + 1'b1 : '0;
   end

   assert_busy_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));

   assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(busy)) |-> (bcnt == CW'(CYCLE_CLKS)));

   assert_write_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   assert_write_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (bcnt < CW'(SLOTS)));

   assert_write_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && busy && $past(busy) && $past(mem_we)) |->
         (mem_addr[PAGE_W-1:0] > $past(mem_addr[PAGE_W-1:0])));

   assert_page_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:PAGE_W]));
endmodule

bind page_write_ctrl page_write_ctrl_chk #(
   .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .busy(busy),
   .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/page_write_ctrl_tb_top.sv
module page_write_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CYC        = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_evt = 1'b0, stop_evt = 1'b0, addr_load = 1'b0;
   logic [10:0] addr_in = '0;
   logic        byte_stb = 1'b0, byte_vol = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        busy, mem_we;
   logic [10:0] mem_addr, rd_addr = '0;
   logic [7:0]  mem_wdata, rd_data;

   int total = 0;
   int bad   = 0;

   logic [7:0] model [2048];
   logic [6:0] b_page;
   logic [3:0] b_slot;
   logic [15:0] b_val;
   logic [7:0]  b_dat [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   page_write_ctrl #(.CYCLE_CLKS(CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
      .addr_load(addr_load), .addr_in(addr_in), .byte_stb(byte_stb),
      .byte_data(byte_data), .byte_vol(byte_vol), .busy(busy), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_start();
      start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
      b_val = '0;
   endtask

   task automatic do_load(input logic [10:0] a);
      addr_in = a; addr_load = 1'b1; @(negedge clk); addr_load = 1'b0;
      b_page = a[10:4]; b_slot = a[3:0];
   endtask

   task automatic do_byte(input logic [7:0] d, input logic v);
      byte_data = d; byte_vol = v; byte_stb = 1'b1; @(negedge clk);
      byte_stb = 1'b0; byte_vol = 1'b0;
      if (!v) begin b_val[b_slot] = 1'b1; b_dat[b_slot] = d; end
      b_slot = b_slot + 1'b1;
   endtask

   // stop pulse, then measure busy length and write count
   task automatic do_stop(input string req);
      int n = 0;
      int w = 0;
      int nv = $countones(b_val);
      stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
      while (busy && n < CYC + 5) begin
         if (mem_we) w++;
         n++;
         @(negedge clk);
      end
      chk(n == ((nv != 0) ? CYC : 0), {req, " busy length"}, n, (nv != 0) ? CYC : 0);
      chk(w == nv, {req, " write count"}, w, nv);
      for (int s = 0; s < 16; s++)
         if (b_val[s]) model[{b_page, 4'(s)}] = b_dat[s];
      b_val = '0;
   endtask

   task automatic check_page(input logic [6:0] pg, input string req);
      int errs = 0;
      int fa = 0, fe = 0;
      for (int s = 0; s < 16; s++) begin
         rd_addr = {pg, 4'(s)}; #1;
         if (rd_data !== model[rd_addr]) begin
            if (errs == 0) begin fa = rd_data; fe = model[rd_addr]; end
            errs++;
         end
      end
      chk(errs == 0, {req, " page contents"}, fa, fe);
   endtask

   task automatic t_reset();
      rd_addr = 11'h000; #1;
      chk(busy == 1'b0, "R9 busy", busy, 0);
      chk(mem_we == 1'b0, "R9 mem_we", mem_we, 0);
      chk(rd_data == 8'h00, "R9 array", rd_data, 0);
   endtask

   task automatic t_full_page();
      do_start(); do_load(11'h120);
      for (int i = 0; i < 16; i++) do_byte(8'(i*3+1), 1'b0);
      do_stop("R3 R5 full");
      check_page(7'h12, "R1 full");
   endtask

   task automatic t_wrap();
      do_start(); do_load(11'h23E);
      for (int i = 0; i < 4; i++) do_byte(8'hA0 + 8'(i), 1'b0);
      do_stop("R3 wrap");
      check_page(7'h23, "R2 wrap");
      check_page(7'h24, "R2 next page");
   endtask

   task automatic t_partial();
      do_start(); do_load(11'h125);
      do_byte(8'h5A, 1'b0); do_byte(8'hC3, 1'b0);
      do_stop("R5 partial");
      check_page(7'h12, "R5 untouched");
   endtask

   task automatic t_vol_only();
      do_start(); do_load(11'h7FF);
      do_byte(8'h33, 1'b1);
      do_stop("R4 vol only");
      check_page(7'h7F, "R8 vol only");
   endtask

   task automatic t_mixed();
      do_start(); do_load(11'h50E);
      do_byte(8'h11, 1'b1); do_byte(8'h22, 1'b0);
      do_stop("R8 mixed");
      check_page(7'h50, "R8 mixed");
   endtask

   task automatic t_empty_stop();
      do_start(); do_load(11'h600);
      do_stop("R4 empty");
   endtask

   task automatic t_start_discard();
      do_start(); do_load(11'h300);
      do_byte(8'h77, 1'b0); do_byte(8'h88, 1'b0);
      do_start();
      do_stop("R7 discard");
      check_page(7'h30, "R7 discard");
   endtask

   task automatic t_busy_ignore();
      int n = 0;
      do_start(); do_load(11'h400);
      do_byte(8'h9C, 1'b0);
      for (int s = 0; s < 16; s++)
         if (b_val[s]) model[{b_page, 4'(s)}] = b_dat[s];
      stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
      chk(busy == 1'b1, "R3 busy started", busy, 1);
      // events during the commit must be dropped
      addr_in = 11'h410; addr_load = 1'b1; @(negedge clk); addr_load = 1'b0;
      byte_data = 8'hEE; byte_stb = 1'b1; @(negedge clk); byte_stb = 1'b0;
      stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
      start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
      while (busy && n < CYC + 5) begin n++; @(negedge clk); end
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R6 no relaunch", busy, 0);
      b_val = '0;
      do_stop("R6 nothing buffered");
      check_page(7'h40, "R6 target page");
      check_page(7'h41, "R6 ignored load");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2048; i++) model[i] = 8'h00;
      b_val = '0; b_page = '0; b_slot = '0;
      for (int i = 0; i < 16; i++) b_dat[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_page();
      t_wrap();
      t_partial();
      t_vol_only();
      t_mixed();
      t_empty_stop();
      t_start_discard();
      t_busy_ignore();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule